// File: doc/BRIEF.md
# Mantissa-Exponent Baud Rate Generator

This block divides a fast input clock into a one-cycle baud enable, `ref_tick`. It raises the enable once every k input cycles, where k = (N+1) * 2^M. N is a 6-bit mantissa and M is a 4-bit exponent, so k ranges from 1 to 64 * 32768. The enable serves as a 16x oversampling reference for a clock-recovery stage. A second enable, `tx_tick`, is derived from it by a fixed divide-by-16 and drives the transmitter bit rate.

Software loads the divisor one byte at a time. One strobe loads the mantissa byte and another loads the exponent byte. The written values are held in staging registers. While the divider runs, they move into the active divisor only when a whole output period ends, so a period is never shortened or split. When the enable input is low, the counters stay at zero, no ticks appear, and the staged divisor is copied into the active divisor at once.

Top module: `mxb_baud_gen`

## Requirements
- R1: After reset, N = 0 and M = 0. With `en` high and no write made, `ref_tick` is high in every cycle, and `tx_tick` is high in every 16th cycle.
- R2: While `en` stays high and the divisor does not change, consecutive `ref_tick` pulses are exactly (N+1) * 2^M cycles apart.
- R3: A cycle with `cfg_wr_lo` high loads N from `cfg_wdata[5:0]`. Bits 7..6 of that byte are ignored.
- R4: A cycle with `cfg_wr_hi` high loads M from `cfg_wdata[3:0]`. Bits 7..4 of that byte are ignored.
- R5: `tx_tick` pulses are exactly 16 * (N+1) * 2^M cycles apart. Every `tx_tick` coincides with a `ref_tick`.
- R6: While `en` is low, both ticks stay low and every counter is held at zero. After `en` rises, the first `ref_tick` comes in the k-th cycle with `en` high, and the first `tx_tick` comes in the 16k-th such cycle.
- R7: A write made while the divider runs leaves the period in progress unchanged. The new divisor applies from the cycle after the next `ref_tick`.
- R8: A write made while `en` is low becomes the active divisor before `en` next rises.
- R9: When k > 1, each `ref_tick` lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable for the divider |
| cfg_wr_lo | input | 1 | Load strobe for the mantissa byte |
| cfg_wr_hi | input | 1 | Load strobe for the exponent byte |
| cfg_wdata | input | 8 | Write data for the configuration bytes |
| ref_tick | output | 1 | One-cycle enable at f_in / k |
| tx_tick | output | 1 | One-cycle enable at f_in / (16k) |

## Verification
The assertions assume that the two write strobes are never high in the same cycle. They also assume that the divisor moves from the staging registers to the active registers in only two situations: at a `ref_tick`, or while `en` is low. The bench issues each write as a single strobe, with the other strobe low. It keeps the largest divisors to partial windows: for N = 63 and M = 15 it only confirms that no tick appears early. Full-period spacing is measured on divisors of up to 32768 cycles.

// File: rtl/mxb_pkg.sv
// Shared widths and types for the mantissa-exponent baud generator.
package mxb_pkg;
    parameter int MANT_W = 6;                 // mantissa field width
    parameter int EXP_W  = 4;                 // exponent field width
    parameter int TX_W   = 4;                 // transmit tap counter width (divide by 16)
    parameter int BYTE_W = 8;                 // configuration byte width
    localparam int PRE_W = (1 << EXP_W) - 1;  // prescaler counter width for the largest exponent

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } mxb_div_t;
endpackage

// File: rtl/mxb_cfg_regs.sv
// Configuration byte registers with staged divisor reload.
// Assumes: at most one write strobe is high per cycle. The staged divisor is
// copied to the active divisor at each whole-period terminal count, or on
// every cycle while the divider is disabled.
module mxb_cfg_regs
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              reload,
    output mxb_div_t          stage_o,
    output mxb_div_t          active_o
);
    mxb_div_t stage_q;
    mxb_div_t active_q;

    // Capture the byte writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            if (wr_lo) stage_q.mant <= wdata[MANT_W-1:0];
            if (wr_hi) stage_q.expo <= wdata[EXP_W-1:0];
        end
    end

    // Move the staged divisor into use only at a period boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (!en || reload) begin
            active_q <= stage_q;
        end
    end

    assign stage_o  = stage_q;
    assign active_o = active_q;
endmodule

// File: rtl/mxb_mant_cnt.sv
// Mantissa stage: divides the input clock by (limit + 1).
// Assumes: limit is stable within a period (guaranteed by the reload logic).
module mxb_mant_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tc
);
    logic [W-1:0] cnt_q;

    assign tc = en && (cnt_q == limit);

    // Count input cycles, wrap at the limit, and clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mxb_pow2_pre.sv
// Exponent stage: passes one of every 2^expo step pulses.
// Assumes: step is a single-cycle pulse and expo is stable within a period.
module mxb_pow2_pre #(
    parameter int EW = 4,
    parameter int CW = (1 << EW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic [EW-1:0] expo,
    output logic          tc
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    // Terminal value 2^expo - 1, built as a thermometer mask.
    for (genvar gi = 0; gi < CW; gi++) begin : g_mask
        assign last_val[gi] = (gi < int'(expo));
    end

    assign tc = step && (cnt_q == last_val);

    // Count mantissa wraps, and clear at the terminal value or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= tc ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mxb_tx_tap.sv
// Transmit tap: passes one of every 2^TW reference ticks.
// Assumes: tick is a single-cycle enable from the reference divider.
module mxb_tx_tap #(
    parameter int TW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic tx_tick
);
    logic [TW-1:0] cnt_q;

    assign tx_tick = tick && (&cnt_q);

    // Advance on each reference tick, wrapping naturally, and clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mxb_baud_gen.sv
// Top level: a mantissa counter followed by a power-of-two prescaler, which
// together produce ref_tick every (N+1)*2^M cycles, and a divide-by-16 tap
// that produces tx_tick.
// Assumes: a synchronous active-low reset, and single-cycle write strobes.
module mxb_baud_gen
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_wr_lo,
    input  logic              cfg_wr_hi,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic              ref_tick,
    output logic              tx_tick
);
    mxb_div_t          stage_w;
    mxb_div_t          active_w;
    logic [MANT_W-1:0] stg_n, act_n;
    logic [EXP_W-1:0]  stg_m, act_m;
    logic              mant_tc;
    logic              pre_tc;

    mxb_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en),
        .wr_lo(cfg_wr_lo), .wr_hi(cfg_wr_hi), .wdata(cfg_wdata),
        .reload(pre_tc), .stage_o(stage_w), .active_o(active_w)
    );

    assign stg_n = stage_w.mant;
    assign stg_m = stage_w.expo;
    assign act_n = active_w.mant;
    assign act_m = active_w.expo;

    mxb_mant_cnt #(.W(MANT_W)) u_mant (
        .clk(clk), .rst_n(rst_n), .en(en), .limit(act_n), .tc(mant_tc)
    );

    mxb_pow2_pre #(.EW(EXP_W), .CW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .step(mant_tc), .expo(act_m), .tc(pre_tc)
    );

    assign ref_tick = pre_tc;

    mxb_tx_tap #(.TW(TX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(pre_tc), .tx_tick(tx_tick)
    );
endmodule

// File: rtl/mxb_baud_chk.sv
// Checker for mxb_baud_gen: the relations between ports and divisor state.
// Assumes: it is bound into the top so that the divisor signals connect by name.
module mxb_baud_chk
    import mxb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              cfg_wr_lo,
    input logic              cfg_wr_hi,
    input logic [BYTE_W-1:0] cfg_wdata,
    input logic              ref_tick,
    input logic              tx_tick,
    input logic [MANT_W-1:0] stg_n,
    input logic [MANT_W-1:0] act_n,
    input logic [EXP_W-1:0]  stg_m,
    input logic [EXP_W-1:0]  act_m
);
    AST_TX_ON_REF:     assert property (@(posedge clk) disable iff (!rst_n) tx_tick |-> ref_tick); // R5
    AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !en |-> (!ref_tick && !tx_tick)); // R6
    AST_LO_CAPTURE:    assert property (@(posedge clk) disable iff (!rst_n) cfg_wr_lo |=> stg_n == $past(cfg_wdata[MANT_W-1:0])); // R3
    AST_HI_CAPTURE:    assert property (@(posedge clk) disable iff (!rst_n) cfg_wr_hi |=> stg_m == $past(cfg_wdata[EXP_W-1:0])); // R4
    AST_HOLD_MIDRUN:   assert property (@(posedge clk) disable iff (!rst_n) (en && !ref_tick) |=> ($stable(act_n) && $stable(act_m))); // R7
    AST_RELOAD_AT_TC:  assert property (@(posedge clk) disable iff (!rst_n) (en && ref_tick) |=> (act_n == $past(stg_n) && act_m == $past(stg_m))); // R7
    AST_IDLE_LOAD:     assert property (@(posedge clk) disable iff (!rst_n) !en |=> (act_n == $past(stg_n) && act_m == $past(stg_m))); // R8
    AST_SINGLE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) (ref_tick && (stg_n != '0 || stg_m != '0)) |=> !ref_tick); // R9
endmodule

bind mxb_baud_gen mxb_baud_chk chk_i (.*);

// File: tb/mxb_baud_gen_tb.sv
// Scoreboard bench: driver tasks queue the expected tick intervals, and a
// monitor measures the intervals seen at the ports and compares them.
module mxb_baud_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_wr_lo = 1'b0;
    logic       cfg_wr_hi = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       ref_tick;
    logic       tx_tick;

    int checks = 0;
    int fails = 0;
    int ref_q[$];
    int tx_q[$];
    int ref_cnt = 0;
    int tx_cnt = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    mxb_baud_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi), .cfg_wdata(cfg_wdata),
        .ref_tick(ref_tick), .tx_tick(tx_tick)
    );

    // Monitor: count enabled cycles between ticks and compare with the queued intervals.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en) begin
                ref_cnt = 0;
                tx_cnt = 0;
                if (ref_tick || tx_tick) begin
                    checks++; fails++;
                    $display("FAIL R6 tick while disabled act=%0b%0b exp=00", ref_tick, tx_tick);
                end
            end else begin
                ref_cnt++;
                tx_cnt++;
                if (ref_tick) begin
                    checks++;
                    if (ref_q.size() == 0) begin
                        fails++;
                        $display("FAIL %s unexpected ref_tick act=%0d exp=none", cur_req, ref_cnt);
                    end else begin
                        int e;
                        e = ref_q.pop_front();
                        if (e != ref_cnt) begin
                            fails++;
                            $display("FAIL %s ref interval act=%0d exp=%0d", cur_req, ref_cnt, e);
                        end
                    end
                    ref_cnt = 0;
                end
                if (tx_tick) begin
                    checks++;
                    if (tx_q.size() == 0) begin
                        fails++;
                        $display("FAIL R5 unexpected tx_tick act=%0d exp=none", tx_cnt);
                    end else begin
                        int e;
                        e = tx_q.pop_front();
                        if (e != tx_cnt) begin
                            fails++;
                            $display("FAIL R5 tx interval act=%0d exp=%0d", tx_cnt, e);
                        end
                    end
                    tx_cnt = 0;
                end
            end
        end
    end

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        @(posedge clk); #2;
        cfg_wr_lo = !hi; cfg_wr_hi = hi; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr_lo = 1'b0; cfg_wr_hi = 1'b0;
    endtask

    task automatic push_expect(input int k, input int periods);
        for (int i = 0; i < periods; i++) ref_q.push_back(k);
        for (int i = 0; i < periods / 16; i++) tx_q.push_back(16 * k);
    endtask

    task automatic drain_check();
        @(posedge clk); #2;
        checks++;
        if (ref_q.size() != 0 || tx_q.size() != 0) begin
            fails++;
            $display("FAIL %s missing ticks act=%0d/%0d pending exp=0/0", cur_req, ref_q.size(), tx_q.size());
        end
        ref_q.delete();
        tx_q.delete();
    endtask

    // Load both bytes while disabled (R8), then run for a whole number of periods.
    task automatic run_case(input logic [7:0] lo, input logic [7:0] hi, input int periods, input string req);
        int k;
        cur_req = req;
        @(posedge clk); #2; en = 1'b0;
        wr_byte(1'b0, lo);
        wr_byte(1'b1, hi);
        k = (int'(lo[5:0]) + 1) * (1 << hi[3:0]);
        push_expect(k, periods);
        @(posedge clk); #2; en = 1'b1;
        repeat (periods * k) @(posedge clk);
        #2; en = 1'b0;
        drain_check();
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: both ticks stay low while reset is held.
        repeat (4) @(posedge clk);
        #2;
        checks++;
        if (ref_tick !== 1'b0 || tx_tick !== 1'b0) begin
            fails++;
            $display("FAIL R1 ticks in reset act=%0b%0b exp=00", ref_tick, tx_tick);
        end
        rst_n = 1'b1;
        // R1: the reset divisor is k=1, so ref_tick fires every cycle and tx_tick every 16th.
        cur_req = "R1";
        push_expect(1, 32);
        @(posedge clk); #2; en = 1'b1;
        repeat (32) @(posedge clk);
        #2; en = 1'b0;
        drain_check();

        run_case(8'h00, 8'h00, 40, "R2 R8");    // N=0, M=0
        run_case(8'h3F, 8'h00, 17, "R2 R3");    // N=63, M=0, k=64
        run_case(8'h05, 8'h03, 33, "R2 R9");    // N=5, M=3, k=48
        run_case(8'h00, 8'h0F, 2,  "R2 R4");    // N=0, M=15, k=32768
        run_case(8'hC2, 8'hF1, 20, "R3 R4");    // bytes with upper bits set: N=2, M=1, k=6
        run_case(8'h02, 8'h02, 36, "R5");       // k=12, two tx periods

        // R2: N=63, M=15 gives no tick inside a 3000-cycle window.
        cur_req = "R2";
        wr_byte(1'b0, 8'h3F);
        wr_byte(1'b1, 8'h0F);
        @(posedge clk); #2; en = 1'b1;
        repeat (3000) @(posedge clk);
        #2; en = 1'b0;
        drain_check();

        // R6: disabling mid-period clears the count, so a full k follows re-enable.
        cur_req = "R6";
        wr_byte(1'b0, 8'h07);
        wr_byte(1'b1, 8'h00);
        @(posedge clk); #2; en = 1'b1;
        repeat (5) @(posedge clk);
        #2; en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        push_expect(8, 2);
        en = 1'b1;
        repeat (16) @(posedge clk);
        #2; en = 1'b0;
        drain_check();

        // R7: a write mid-period leaves the current period alone; later periods use the new k.
        cur_req = "R7";
        wr_byte(1'b0, 8'h03);
        wr_byte(1'b1, 8'h00);
        ref_q.push_back(4);
        ref_q.push_back(4);
        for (int i = 0; i < 6; i++) ref_q.push_back(2);
        @(posedge clk); #2; en = 1'b1;
        repeat (5) @(posedge clk);
        #2; cfg_wr_lo = 1'b1; cfg_wdata = 8'h01;
        @(posedge clk); #2; cfg_wr_lo = 1'b0;
        repeat (14) @(posedge clk);
        #2; en = 1'b0;
        drain_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule